// File: doc/BRIEF.md
# Receive Character-Timeout Interrupt Generator

This block sits beside a UART receive FIFO. It raises a timeout flag when characters are waiting in the FIFO but nothing has happened on either side for a while: no new character has arrived from the line, and software has not read the FIFO. The flag goes to the interrupt identification logic, where it has the same rank as the received-data-available source. Software can therefore collect a partial FIFO load that never reaches the trigger level.

The wait is counted in character times taken from the 16x receive baud tick, so it scales with the baud rate. One character time is the full frame: start bit, data bits, the parity bit when enabled, and both stop bits when two are programmed. The flag is raised after four character times of quiet. The rules for restarting the timer change once the flag is set. The block has no streaming data path, so every pin is a plain control or status level or strobe.

Top module: `rx_char_timeout`

## Requirements
- R1: While `rst_n` is low, `timeout_pending` is 0 and the quiet timer is zero. After reset is released, the first timeout needs a full threshold of ticks.
- R2: A frame is 16 × (1 + D + P + S) ticks. D = 5 + `data_len_sel`, where codes 0, 1, 2 and 3 give 5 to 8 data bits. P = `parity_on`. S = 1 + `stop_two`. The threshold is 4 × the frame length, from 448 to 768 ticks.
- R3: When no strobe is present, the timer counts only cycles with `baud_tick` = 1. `timeout_pending` rises on the clock edge that takes in the threshold-th such tick, counted from the last restart.
- R4: Setting `stop_two` lengthens the threshold by exactly 64 ticks compared with the same format using one stop bit.
- R5: While not pending, a `rx_char` or `fifo_rd` strobe restarts the timer from zero at that edge. The next timeout then needs a full threshold of ticks.
- R6: While pending, a `fifo_rd` strobe clears `timeout_pending` at that edge and restarts the timer from zero.
- R7: While pending, a `rx_char` strobe has no effect, and `timeout_pending` stays 1.
- R8: A `fifo_count` of 0 clears `timeout_pending` and the timer at the next edge.
- R9: When `fifo_en` = 0 or `rx_irq_en` = 0, the flag and the timer are cleared at the next edge and no ticks are counted.
- R10: Once set, `timeout_pending` stays 1 until a clear from R6, R8 or R9 occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle 16x receive baud tick |
| rx_char | input | 1 | Strobe: a character was written into the FIFO |
| fifo_rd | input | 1 | Strobe: the CPU read a character from the FIFO |
| fifo_count | input | CNT_W (5) | Number of characters currently in the FIFO |
| fifo_en | input | 1 | Receive FIFO enabled |
| rx_irq_en | input | 1 | Receive interrupts enabled |
| data_len_sel | input | 2 | Data length code (0..3 means 5..8 bits) |
| parity_on | input | 1 | Parity bit present in the frame |
| stop_two | input | 1 | Two stop bits programmed |
| timeout_pending | output | 1 | Character-timeout interrupt pending |

## Verification
The timeout is measured first with a tick on every cycle, using the shortest format, the longest format, and the longest format with one stop bit. Comparing these fire times separates the frame-length arithmetic from an off-by-one in the count and from a missing second stop bit. Directed sequences then send strobes before and after the flag rises. These show whether a character arrival is wrongly treated as a clear, and whether a read or a flush really zeroes the timer, because each is followed by a full re-measurement. Long random phases follow. They alternate quiet stretches, busy stretches with frequent strobes, and toggling enables and occupancy, all at irregular tick spacing. Every cycle is compared with a bench model built from the requirements.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  // start + minimum data + one stop, before optional fields
  localparam int unsigned BASE_BITS      = 7;
  localparam int unsigned MAX_FRAME_BITS = 12;

  function automatic int unsigned frame_bits(input logic [1:0] dsel,
                                             input logic       par,
                                             input logic       stop2);
    return BASE_BITS + int'(unsigned'(dsel)) + int'(unsigned'(par)) + int'(unsigned'(stop2));
  endfunction
endpackage

// File: rtl/rxto_frame_len.sv
module rxto_frame_len
  import rxto_pkg::*;
#(
  parameter int unsigned OVS   = 16,
  parameter int unsigned CHARS = 4,
  parameter int unsigned TH_W  = 10
) (
  input  logic [1:0]      data_len_sel,
  input  logic            parity_on,
  input  logic            stop_two,
  output logic [TH_W-1:0] threshold
);
  // quiet limit in baud ticks: CHARS whole frames
  always_comb begin
    threshold = TH_W'(frame_bits(data_len_sel, parity_on, stop_two) * OVS * CHARS);
  end
endmodule

// File: rtl/rxto_quiet_timer.sv
module rxto_quiet_timer #(
  parameter int unsigned TH_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  input  logic [TH_W-1:0] threshold,
  output logic            at_limit
);
  logic [TH_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end

  // true when one more tick reaches the threshold
  assign at_limit = ({1'b0, cnt} + 1'b1) >= {1'b0, threshold};

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + 1'b1)); // R3

endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout
  import rxto_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned OVS        = 16,
  parameter int unsigned CHARS      = 4,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned TH_W      = $clog2(CHARS * OVS * MAX_FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             rx_char,
  input  logic             fifo_rd,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             fifo_en,
  input  logic             rx_irq_en,
  input  logic [1:0]       data_len_sel,
  input  logic             parity_on,
  input  logic             stop_two,
  output logic             timeout_pending
);
  logic [TH_W-1:0] threshold;
  logic            at_limit;
  logic            flush, restart, adv, fire, clr;

  rxto_frame_len #(.OVS(OVS), .CHARS(CHARS), .TH_W(TH_W)) u_len (
    .data_len_sel (data_len_sel),
    .parity_on    (parity_on),
    .stop_two     (stop_two),
    .threshold    (threshold)
  );

  // inactive or nothing waiting: wipe everything
  assign flush   = !fifo_en || !rx_irq_en || (fifo_count == '0);
  // clearing rule depends on whether a timeout already stands
  assign restart = timeout_pending ? fifo_rd : (rx_char || fifo_rd);
  assign adv     = baud_tick && !timeout_pending && !flush && !restart;
  assign fire    = adv && at_limit;
  assign clr     = flush || restart || fire;

  rxto_quiet_timer #(.TH_W(TH_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .adv       (adv),
    .threshold (threshold),
    .at_limit  (at_limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                          timeout_pending <= 1'b0;
    else if (flush)                      timeout_pending <= 1'b0;
    else if (timeout_pending && fifo_rd) timeout_pending <= 1'b0;
    else if (fire)                       timeout_pending <= 1'b1;
  end

  AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == '0) |=> !timeout_pending); // R8
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en || !rx_irq_en) |=> !timeout_pending); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_pending && fifo_rd) |=> !timeout_pending); // R6
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_pending && !fifo_rd && fifo_en && rx_irq_en && fifo_count != '0)
      |=> timeout_pending); // R10
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_pending) |-> ($past(baud_tick) && !$past(rx_char) && !$past(fifo_rd))); // R3

endmodule

// File: tb/test_rx_char_timeout.sv
module test_rx_char_timeout;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0, rx_char = 1'b0, fifo_rd = 1'b0;
  logic [CNT_W-1:0] fifo_count = '0;
  logic fifo_en = 1'b0, rx_irq_en = 1'b0;
  logic [1:0] data_len_sel = 2'd0;
  logic parity_on = 1'b0, stop_two = 1'b0;
  logic timeout_pending;

  int checks = 0;
  int errors = 0;
  int ec = 0;
  bit ep = 1'b0;

  always #10 clk = ~clk;

  rx_char_timeout i_rx_char_timeout (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_char(rx_char),
    .fifo_rd(fifo_rd), .fifo_count(fifo_count), .fifo_en(fifo_en),
    .rx_irq_en(rx_irq_en), .data_len_sel(data_len_sel), .parity_on(parity_on),
    .stop_two(stop_two), .timeout_pending(timeout_pending)
  );

  function automatic int exp_th(input int dsel, input int par, input int s2);
    return 4 * 16 * (1 + (5 + dsel) + par + (1 + s2));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: update model from inputs at the edge, compare at the next negedge
  task automatic cyc(input string tag);
    @(posedge clk);
    if (!rst_n) begin ec = 0; ep = 1'b0; end
    else if (!fifo_en || !rx_irq_en || fifo_count == 0) begin ec = 0; ep = 1'b0; end
    else if (ep) begin if (fifo_rd) begin ep = 1'b0; ec = 0; end end
    else if (rx_char || fifo_rd) ec = 0;
    else if (baud_tick) begin
      if (ec + 1 >= exp_th(int'(data_len_sel), int'(parity_on), int'(stop_two))) begin
        ep = 1'b1; ec = 0;
      end else ec = ec + 1;
    end
    @(negedge clk);
    check(tag, int'(timeout_pending), int'(ep));
  endtask

  task automatic set_fmt(input int d, input int p, input int s);
    data_len_sel = 2'(d); parity_on = p[0]; stop_two = s[0];
  endtask

  // restart with a read, then tick every cycle and count cycles to the flag
  task automatic measure(input string tag, input int exp);
    int n = 0;
    fifo_rd = 1'b1; baud_tick = 1'b0; cyc(tag);
    fifo_rd = 1'b0; baud_tick = 1'b1;
    while (!timeout_pending && n < 2000) begin cyc(tag); n++; end
    baud_tick = 1'b0;
    check(tag, n, exp);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    fifo_count = 5'd3; fifo_en = 1'b1; rx_irq_en = 1'b1; baud_tick = 1'b1;
    repeat (3) cyc("R1");
    @(negedge clk);
    check("R1 reset state", int'(timeout_pending), 0);
    rst_n = 1'b1;
    baud_tick = 1'b0;
    // R1/R2/R3: shortest format from reset, tick every cycle
    set_fmt(0, 0, 0);
    measure("R2 min format", exp_th(0, 0, 0));
    check("R2 min threshold 448", exp_th(0, 0, 0), 448);
    set_fmt(3, 1, 1);
    measure("R2 max format", exp_th(3, 1, 1));
    set_fmt(3, 1, 0);
    measure("R4 one stop bit", exp_th(3, 1, 1) - 64);
    set_fmt(3, 1, 1);
    measure("R4 two stop bits", 768);
    // R7: character arrival while pending is ignored
    rx_char = 1'b1; cyc("R7"); rx_char = 1'b0;
    check("R7 still pending", int'(timeout_pending), 1);
    repeat (5) cyc("R10");
    check("R10 holds", int'(timeout_pending), 1);
    // R6: read clears, then full threshold again
    fifo_rd = 1'b1; cyc("R6"); fifo_rd = 1'b0;
    check("R6 cleared by read", int'(timeout_pending), 0);
    baud_tick = 1'b1; repeat (700) cyc("R6"); baud_tick = 1'b0;
    rx_char = 1'b1; cyc("R5"); rx_char = 1'b0;
    baud_tick = 1'b1; repeat (700) cyc("R5"); baud_tick = 1'b0;
    check("R5 rx restarts timer", int'(timeout_pending), 0);
    baud_tick = 1'b1; repeat (68) cyc("R5"); baud_tick = 1'b0;
    check("R5 fires after full threshold", int'(timeout_pending), 1);
    // R3: cycles without tick do not count
    set_fmt(0, 0, 0);
    fifo_rd = 1'b1; cyc("R3"); fifo_rd = 1'b0;
    for (int i = 0; i < 2 * 447; i++) begin baud_tick = i[0]; cyc("R3"); end
    check("R3 one tick short", int'(timeout_pending), 0);
    baud_tick = 1'b0; repeat (20) cyc("R3");
    baud_tick = 1'b1; cyc("R3"); baud_tick = 1'b0;
    check("R3 last tick fires", int'(timeout_pending), 1);
    // R8: empty FIFO clears flag and timer
    fifo_count = '0; cyc("R8");
    check("R8 empty clears", int'(timeout_pending), 0);
    fifo_count = 5'd1; baud_tick = 1'b1; repeat (447) cyc("R8");
    check("R8 timer zeroed", int'(timeout_pending), 0);
    cyc("R8");
    check("R8 refire", int'(timeout_pending), 1);
    // R9: enables
    fifo_en = 1'b0; cyc("R9"); fifo_en = 1'b1;
    check("R9 fifo off clears", int'(timeout_pending), 0);
    rx_irq_en = 1'b0; repeat (600) cyc("R9");
    check("R9 irq off no count", int'(timeout_pending), 0);
    rx_irq_en = 1'b1; repeat (447) cyc("R9");
    check("R9 timer zeroed", int'(timeout_pending), 0);
    baud_tick = 1'b0;
    // random phases against the bench model
    for (int ph = 0; ph < 24; ph++) begin
      int mode = int'($urandom_range(0, 2));
      set_fmt(int'($urandom_range(0, 3)), int'($urandom_range(0, 1)), int'($urandom_range(0, 1)));
      for (int c = 0; c < 1800; c++) begin
        baud_tick  = ($urandom_range(0, 2) != 0);
        rx_char    = (mode == 1) ? ($urandom_range(0, 60) == 0) : ($urandom_range(0, 4000) == 0);
        fifo_rd    = (mode == 1) ? ($urandom_range(0, 80) == 0) : ($urandom_range(0, 3000) == 0);
        fifo_count = (mode == 2 && $urandom_range(0, 200) == 0) ? '0 : 5'($urandom_range(1, 16));
        fifo_en    = !(mode == 2 && $urandom_range(0, 300) == 0);
        rx_irq_en  = !(mode == 2 && $urandom_range(0, 300) == 0);
        cyc("R10 random");
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule